// File: doc/BRIEF.md
# Guarded Interrupt Vector Base Selector

This block holds one control register of a small microcontroller. The register decides where the interrupt vector table lives. With the select bit low, the table starts at program flash address 0. With the select bit high, the table starts at the first word of the boot loader section. The start of the boot section is worked out from fuse inputs that set the boot size. A CPU core reads and writes the register through a simple write-strobe/read-data port. The block drives the resulting vector base address to the interrupt logic.

The select bit is guarded so that it cannot change by accident. Software first writes a one to a change-enable bit. That opens a short window, and only inside that window can a write with change-enable at zero set the new select value. From the moment the window opens until just after the instruction that follows the select write, the block raises a hardware interrupt-block signal. The CPU's own global interrupt-enable flag is left alone. The block uses a per-cycle instruction-retire strobe to find that following instruction.

The block also blocks interrupts when a lock input forbids them in the flash region now being executed. It works out the region by comparing the fetch address with the fuse-derived boot start.

Top module: `ivec_base_sel`

## Requirements
- R1: After reset, the register reads 0x00, the vector base is 0 and the interrupt-block output is low while both lock inputs are low.
- R2: The register read value carries change-enable at bit 0, vector select at bit 1 and pull-up disable at bit 4, and all other bits read zero. Any register write loads bit 4 directly, whatever the window state.
- R3: When the select bit is low, the vector base is 0. When it is high, the vector base is 2^ADDR_W − (BOOT_MAX_WORDS >> bootSizeFuse). With the defaults (13-bit word address, 1024 words), fuse codes 0, 1, 2 and 3 give 0x1C00, 0x1E00, 0x1F00 and 0x1F80.
- R4: A register write with bit 0 set opens the change-enable window. From the next cycle, change-enable reads 1 and the interrupt-block output is high. Such a write does not change the select bit.
- R5: A write with bit 0 clear that is latched on any of the four clock edges after the enabling edge loads bit 1 into the select bit, and change-enable reads 0 from the next cycle.
- R6: A write with bit 0 clear made while change-enable reads 0 leaves the select bit unchanged.
- R7: With no select write, change-enable reads 1 for exactly four cycles after the enabling edge and then clears itself. The interrupt block releases at the same time.
- R8: After a select write, the interrupt block stays high through the next cycle in which the retire strobe is high, and drops in the cycle after that.
- R9: An enabling write made while the window is open restarts the four-cycle window from that write.
- R10: When the select bit is high and the application lock input is high, the interrupt block is high whenever the fetch address is below the boot start, and it is not raised by this lock when the address is at or above the boot start.
- R11: When the select bit is low and the boot lock input is high, the interrupt block is high whenever the fetch address is at or above the boot start, and it is not raised by this lock below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read value |
| instrRetire | input | 1 | High in each cycle an instruction retires |
| bootSizeFuse | input | 2 | Boot section size code |
| appLockProg | input | 1 | Interrupts forbidden in the application section when vectors are in boot |
| bootLockProg | input | 1 | Interrupts forbidden in the boot section when vectors are in the application section |
| fetchAddr | input | ADDR_W | Current instruction fetch word address |
| vecBase | output | ADDR_W | Interrupt vector table base word address |
| irqBlock | output | 1 | High when interrupt acceptance must be held off |
| pullupDisable | output | 1 | Pull-up disable control bit |

## Verification
The assertions assume that regWrEn is a one-cycle strobe per write, so each write is treated as a separate instruction. They also assume that the fuse and lock inputs hold steady while the select bit matters for gating. The bench drives every write as a single-cycle pulse. It changes fuses and locks only between scenarios, when no window or hold is pending, and it sets the retire strobe only in cycles it picks on purpose. This lets each window edge and each hold release fall on a known clock edge.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
  typedef struct packed {
    logic selLoad;
    logic selVal;
    logic pudLoad;
    logic pudVal;
  } ivsStrobe_t;

  localparam int CE_BIT  = 0;
  localparam int SEL_BIT = 1;
  localparam int PUD_BIT = 4;
endpackage

// File: rtl/ivs_ctrl.sv
module ivs_ctrl
  import ivs_pkg::*;
#(
  parameter int WIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       instrRetire,
  output ivsStrobe_t strobe,
  output logic       ceOpen,
  output logic       seqBlock
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYCLES);

  logic [CNT_W-1:0] winCnt;
  logic             holdPend;
  logic             enWrite;
  logic             selWrite;

  assign ceOpen   = (winCnt != '0);
  assign enWrite  = regWrEn && regWrData[CE_BIT];
  assign selWrite = regWrEn && !regWrData[CE_BIT] && ceOpen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winCnt <= '0;
    end else if (enWrite) begin
      winCnt <= CNT_LOAD;
    end else if (selWrite) begin
      winCnt <= '0;
    end else if (ceOpen) begin
      winCnt <= winCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdPend <= 1'b0;
    end else if (selWrite) begin
      holdPend <= 1'b1;
    end else if (holdPend && instrRetire) begin
      holdPend <= 1'b0;
    end
  end

  assign seqBlock = ceOpen || holdPend;

  always_comb begin
    strobe.selLoad = selWrite;
    strobe.selVal  = regWrData[SEL_BIT];
    strobe.pudLoad = regWrEn;
    strobe.pudVal  = regWrData[PUD_BIT];
  end

  assert_open_after_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regWrData[CE_BIT]) |=> (ceOpen && seqBlock));

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    winCnt <= CNT_LOAD);

  assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (holdPend && !instrRetire && !(regWrEn && regWrData[CE_BIT])) |=> seqBlock);
endmodule

// File: rtl/ivs_datapath.sv
module ivs_datapath
  import ivs_pkg::*;
#(
  parameter int ADDR_W         = 13,
  parameter int BOOT_MAX_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ivsStrobe_t        strobe,
  input  logic              ceOpen,
  input  logic [1:0]        bootSizeFuse,
  input  logic              appLockProg,
  input  logic              bootLockProg,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [7:0]        regRdData,
  output logic [ADDR_W-1:0] vecBase,
  output logic              lockBlock,
  output logic              pullupDisable
);
  localparam logic [ADDR_W:0] FLASH_WORDS = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] BOOT_MAX    = (ADDR_W+1)'(BOOT_MAX_WORDS);

  logic              selReg;
  logic              pudReg;
  logic [ADDR_W:0]   bootSize;
  logic [ADDR_W:0]   bootStartWide;
  logic [ADDR_W-1:0] bootStart;
  logic              inBoot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selReg <= 1'b0;
      pudReg <= 1'b0;
    end else begin
      if (strobe.selLoad) selReg <= strobe.selVal;
      if (strobe.pudLoad) pudReg <= strobe.pudVal;
    end
  end

  assign bootSize      = BOOT_MAX >> bootSizeFuse;
  assign bootStartWide = FLASH_WORDS - bootSize;
  assign bootStart     = bootStartWide[ADDR_W-1:0];
  assign inBoot        = (fetchAddr >= bootStart);

  assign vecBase   = selReg ? bootStart : '0;
  assign lockBlock = (selReg && appLockProg && !inBoot) ||
                     (!selReg && bootLockProg && inBoot);
  assign pullupDisable = pudReg;

  always_comb begin
    regRdData          = '0;
    regRdData[CE_BIT]  = ceOpen;
    regRdData[SEL_BIT] = selReg;
    regRdData[PUD_BIT] = pudReg;
  end

  assert_sel_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.selLoad |=> $stable(selReg));

  assert_vec_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !regRdData[SEL_BIT] |-> (vecBase == '0));
endmodule

// File: rtl/ivec_base_sel.sv
module ivec_base_sel
  import ivs_pkg::*;
#(
  parameter int ADDR_W         = 13,
  parameter int BOOT_MAX_WORDS = 1024,
  parameter int WIN_CYCLES     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              instrRetire,
  input  logic [1:0]        bootSizeFuse,
  input  logic              appLockProg,
  input  logic              bootLockProg,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] vecBase,
  output logic              irqBlock,
  output logic              pullupDisable
);
  ivsStrobe_t strobe;
  logic       ceOpen;
  logic       seqBlock;
  logic       lockBlock;

  ivs_ctrl #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .instrRetire(instrRetire), .strobe(strobe), .ceOpen(ceOpen),
    .seqBlock(seqBlock)
  );

  ivs_datapath #(.ADDR_W(ADDR_W), .BOOT_MAX_WORDS(BOOT_MAX_WORDS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ceOpen(ceOpen),
    .bootSizeFuse(bootSizeFuse), .appLockProg(appLockProg),
    .bootLockProg(bootLockProg), .fetchAddr(fetchAddr),
    .regRdData(regRdData), .vecBase(vecBase), .lockBlock(lockBlock),
    .pullupDisable(pullupDisable)
  );

  assign irqBlock = seqBlock || lockBlock;

  assert_sel_write_needs_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdData[SEL_BIT] != $past(regRdData[SEL_BIT])) |-> $past(regRdData[CE_BIT] && regWrEn));
endmodule

// File: tb/ivec_base_sel_bench.sv
module ivec_base_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        instrRetire = 1'b0;
  logic [1:0]  bootSizeFuse = '0;
  logic        appLockProg = 1'b0;
  logic        bootLockProg = 1'b0;
  logic [12:0] fetchAddr = '0;
  logic [12:0] vecBase;
  logic        irqBlock;
  logic        pullupDisable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ivec_base_sel u_ivec_base_sel (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .instrRetire(instrRetire),
    .bootSizeFuse(bootSizeFuse), .appLockProg(appLockProg),
    .bootLockProg(bootLockProg), .fetchAddr(fetchAddr), .vecBase(vecBase),
    .irqBlock(irqBlock), .pullupDisable(pullupDisable)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic retire();
    instrRetire = 1'b1;
    @(posedge clk); @(negedge clk);
    instrRetire = 1'b0;
  endtask

  task automatic setSel(input logic v);
    wr(8'h01);
    wr({6'b0, v, 1'b0});
    retire();
  endtask

  task automatic t_reset();
    check(regRdData, 8'h00, "R1 read");
    check(vecBase, 0, "R1 vecBase");
    check(irqBlock, 0, "R1 irqBlock");
  endtask

  task automatic t_layout();
    wr(8'hFF);
    check(regRdData, 8'h11, "R2 layout after 0xFF");
    check(pullupDisable, 1, "R2 pud out");
    repeat (5) @(negedge clk);
    wr(8'hEE);
    check(regRdData, 8'h00, "R2 sel unchanged, pud cleared");
  endtask

  task automatic t_window();
    wr(8'h01);
    check(regRdData[0], 1, "R4 ce set");
    check(irqBlock, 1, "R4 block on");
    check(regRdData[1], 0, "R4 sel untouched");
    repeat (3) @(negedge clk);
    check(irqBlock, 1, "R7 block in last window cycle");
    @(negedge clk);
    check(regRdData[0], 0, "R7 ce expired");
    check(irqBlock, 0, "R7 block released");
  endtask

  task automatic t_late();
    wr(8'h01);
    repeat (4) @(negedge clk);
    wr(8'h02);
    check(regRdData[1], 0, "R6 late write ignored");
    check(irqBlock, 0, "R6 no hold after ignored write");
  endtask

  task automatic t_edge_accept();
    wr(8'h01);
    repeat (3) @(negedge clk);
    wr(8'h02);
    check(regRdData[1:0], 2'b10, "R5 sel set on fourth edge, ce clear");
    check(vecBase, 13'h1C00, "R3 vecBase fuse0");
    check(irqBlock, 1, "R8 hold after sel write");
    repeat (2) @(negedge clk);
    check(irqBlock, 1, "R8 hold without retire");
    instrRetire = 1'b1;
    #0;
    check(irqBlock, 1, "R8 still held in retire cycle");
    @(posedge clk); @(negedge clk);
    instrRetire = 1'b0;
    check(irqBlock, 0, "R8 released after retire");
  endtask

  task automatic t_fuses();
    bootSizeFuse = 2'd1; #1;
    check(vecBase, 13'h1E00, "R3 fuse1");
    bootSizeFuse = 2'd2; #1;
    check(vecBase, 13'h1F00, "R3 fuse2");
    bootSizeFuse = 2'd3; #1;
    check(vecBase, 13'h1F80, "R3 fuse3");
    bootSizeFuse = 2'd0; #1;
  endtask

  task automatic t_restart();
    wr(8'h01);
    repeat (2) @(negedge clk);
    wr(8'h01);
    repeat (3) @(negedge clk);
    check(regRdData[0], 1, "R9 window restarted");
    wr(8'h00);
    check(regRdData[1], 0, "R9 sel cleared in restarted window");
    retire();
    check(vecBase, 0, "R3 vecBase zero when sel low");
  endtask

  task automatic t_locks();
    bootLockProg = 1'b1; fetchAddr = 13'h1C00; #1;
    check(irqBlock, 1, "R11 boot lock in boot");
    fetchAddr = 13'h1BFF; #1;
    check(irqBlock, 0, "R11 boot lock in app");
    bootLockProg = 1'b0; appLockProg = 1'b1; fetchAddr = 13'h0100; #1;
    check(irqBlock, 0, "R10 app lock ignored when sel low");
    appLockProg = 1'b0;
    setSel(1'b1);
    appLockProg = 1'b1; fetchAddr = 13'h0100; #1;
    check(irqBlock, 1, "R10 app lock in app");
    fetchAddr = 13'h1C00; #1;
    check(irqBlock, 0, "R10 app lock in boot");
    bootLockProg = 1'b1; #1;
    check(irqBlock, 0, "R11 boot lock ignored when sel high");
    appLockProg = 1'b0; bootLockProg = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_window();
    t_late();
    t_edge_accept();
    t_fuses();
    t_restart();
    t_locks();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule